// File: doc/BRIEF.md
# Auxiliary Memory Bank Address Translator

This block maps a 16-bit CPU address onto a 128 KB RAM made of two 64 KB halves: the main half at physical offset 0x00000 and the auxiliary half at 0x10000. For each access it picks a half and drives a 17-bit physical address and a RAM enable. Six soft-switch flags control the choice: alternate zero page, read-aux, write-aux, display store, page select and hi-res. Reads and writes to the same region can go to different halves.

The flags are sampled on the clock edge and turned into a set of registered region selects. The address path from CPU address to physical address is purely combinational, so an access sees the selects that were registered at the last edge. The I/O page, ROM and upper RAM area (0xC000 to 0xFFFF) belong to other logic, and this block does not enable RAM there.

Top module: `aux_bank_xlate`

## Requirements
- R1: For every enabled access, phys_addr[15:0] equals cpu_addr, and phys_addr[16] is 1 when the auxiliary half is chosen and 0 for the main half.
- R2: Addresses 0x0000 to 0x01FF go to the auxiliary half for both reads and writes when the registered alternate-zero-page flag is 1, and to the main half when it is 0.
- R3: Addresses 0x0200 to 0x03FF, 0x0800 to 0x1FFF and 0x4000 to 0xBFFF use a 2-bit select whose bit 0 is the read-aux flag and bit 1 the write-aux flag: 0 is read main/write main, 1 read aux/write main, 2 read main/write aux, 3 read aux/write aux.
- R4: For 0x2000 to 0x3FFF, when display store and hi-res are both 1, page select 1 sends reads and writes to the auxiliary half and page select 0 sends both to the main half, whatever the read-aux and write-aux flags.
- R5: For 0x2000 to 0x3FFF, when display store or hi-res is 0, the region follows the R3 select.
- R6: For 0x0400 to 0x07FF, when display store is 1, page select alone picks the half for both reads and writes (1 is auxiliary); otherwise the region follows the R3 select.
- R7: ram_en is 1 exactly when mem_req is 1 and cpu_addr is below 0xC000; it is 0 for 0xC000 to 0xFFFF.
- R8: While reset is active and in the first cycle after it, every region maps reads and writes to the main half, whatever the flags.
- R9: A flag change takes effect on the next rising clock edge, no later and no earlier; the address path itself has no clock latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| mem_req | input | 1 | Access request strobe |
| mem_wr | input | 1 | 1 for write, 0 for read |
| sw_alt_zp | input | 1 | Alternate zero page flag |
| sw_rd_aux | input | 1 | Read from auxiliary half |
| sw_wr_aux | input | 1 | Write to auxiliary half |
| sw_store | input | 1 | Display store flag |
| sw_page2 | input | 1 | Display page select |
| sw_hires | input | 1 | Hi-res flag |
| phys_addr | output | 17 | Physical RAM address |
| ram_en | output | 1 | RAM enable |

## Verification
A wrong registered select shows up at once as a flipped phys_addr[16] on the next access to that region, and with the RAM model it shows as data written through one setting and read back from the wrong half. A select that lags or leads the flags shows in the cycle straddling the flag change, which the bench probes on both sides of the edge. Write patterns go through each select combination and come back through the opposite setting, so cross-contamination between halves is caught on the very next read.

// File: rtl/aux_xlate_pkg.sv
package aux_xlate_pkg;

    localparam int CPU_AW  = 16;
    localparam int PHYS_AW = CPU_AW + 1;

    // Region boundaries (first address of each region)
    localparam logic [CPU_AW-1:0] LO_GEN_BASE  = 16'h0200;
    localparam logic [CPU_AW-1:0] TEXT_BASE    = 16'h0400;
    localparam logic [CPU_AW-1:0] MID_GEN_BASE = 16'h0800;
    localparam logic [CPU_AW-1:0] HIRES_BASE   = 16'h2000;
    localparam logic [CPU_AW-1:0] HI_GEN_BASE  = 16'h4000;
    localparam logic [CPU_AW-1:0] FOREIGN_BASE = 16'hC000;

    typedef enum logic [2:0] {
        RG_ZP    = 3'd0,
        RG_GEN   = 3'd1,
        RG_TEXT  = 3'd2,
        RG_HIRES = 3'd3,
        RG_NONE  = 3'd4
    } region_e;

    // Each 2-bit select: bit 0 = read aux, bit 1 = write aux
    typedef struct packed {
        logic       zp_aux;
        logic [1:0] gen_sel;
        logic [1:0] text_sel;
        logic [1:0] hires_sel;
    } bank_sel_t;

    typedef struct packed {
        logic alt_zp;
        logic rd_aux;
        logic wr_aux;
        logic store;
        logic page2;
        logic hires;
    } sw_flags_t;

endpackage

// File: rtl/axl_sel_reg.sv
module axl_sel_reg
    import aux_xlate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sw_flags_t flags,
    output bank_sel_t sel_q
);
    bank_sel_t sel_d;
    logic [1:0] rw_sel;

    always_comb begin
        rw_sel          = {flags.wr_aux, flags.rd_aux};
        sel_d           = '0;
        sel_d.zp_aux    = flags.alt_zp;
        sel_d.gen_sel   = rw_sel;
        sel_d.text_sel  = flags.store ? {2{flags.page2}} : rw_sel;
        sel_d.hires_sel = (flags.store && flags.hires) ? {2{flags.page2}} : rw_sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    // Selects return to main after a reset cycle
    assert_reset_main_R8: assert property (@(posedge clk)
        !$past(rst_n) |-> (sel_q == '0));
endmodule

// File: rtl/axl_region_dec.sv
module axl_region_dec
    import aux_xlate_pkg::*;
(
    input  logic [CPU_AW-1:0] addr,
    output region_e           region
);
    always_comb begin
        if (addr >= FOREIGN_BASE)      region = RG_NONE;
        else if (addr >= HI_GEN_BASE)  region = RG_GEN;
        else if (addr >= HIRES_BASE)   region = RG_HIRES;
        else if (addr >= MID_GEN_BASE) region = RG_GEN;
        else if (addr >= TEXT_BASE)    region = RG_TEXT;
        else if (addr >= LO_GEN_BASE)  region = RG_GEN;
        else                           region = RG_ZP;
    end
endmodule

// File: rtl/axl_half_pick.sv
module axl_half_pick
    import aux_xlate_pkg::*;
(
    input  region_e   region,
    input  bank_sel_t sel,
    input  logic      wr,
    output logic      aux,
    output logic      in_ram
);
    logic [1:0] pair;

    always_comb begin
        in_ram = 1'b1;
        pair   = 2'b00;
        unique case (region)
            RG_ZP:    pair = {2{sel.zp_aux}};
            RG_GEN:   pair = sel.gen_sel;
            RG_TEXT:  pair = sel.text_sel;
            RG_HIRES: pair = sel.hires_sel;
            default:  in_ram = 1'b0;
        endcase
        aux = wr ? pair[1] : pair[0];
    end
endmodule

// File: rtl/aux_bank_xlate.sv
module aux_bank_xlate
    import aux_xlate_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CPU_AW-1:0]   cpu_addr,
    input  logic                mem_req,
    input  logic                mem_wr,
    input  logic                sw_alt_zp,
    input  logic                sw_rd_aux,
    input  logic                sw_wr_aux,
    input  logic                sw_store,
    input  logic                sw_page2,
    input  logic                sw_hires,
    output logic [PHYS_AW-1:0]  phys_addr,
    output logic                ram_en
);
    sw_flags_t flags;
    bank_sel_t sel_q;
    region_e   region;
    logic      aux;
    logic      in_ram;

    assign flags = '{alt_zp: sw_alt_zp, rd_aux: sw_rd_aux, wr_aux: sw_wr_aux,
                     store: sw_store, page2: sw_page2, hires: sw_hires};

    axl_sel_reg u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .flags (flags),
        .sel_q (sel_q)
    );

    axl_region_dec u_dec (
        .addr   (cpu_addr),
        .region (region)
    );

    axl_half_pick u_pick (
        .region (region),
        .sel    (sel_q),
        .wr     (mem_wr),
        .aux    (aux),
        .in_ram (in_ram)
    );

    assign phys_addr = in_ram ? {aux, cpu_addr} : {1'b0, cpu_addr};
    assign ram_en    = mem_req & in_ram;

    // Low address bits pass straight through
    assert_addr_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> (phys_addr[CPU_AW-1:0] == cpu_addr));

    // Zero page follows the flag registered on the previous edge
    assert_zp_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ram_en && cpu_addr < LO_GEN_BASE)
        |-> (phys_addr[CPU_AW] == $past(sw_alt_zp)));

    // Display store with hi-res: page select decides the hi-res region
    assert_hires_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sw_store && sw_hires) && ram_en &&
         cpu_addr >= HIRES_BASE && cpu_addr < HI_GEN_BASE)
        |-> (phys_addr[CPU_AW] == $past(sw_page2)));

    // Upper area never enabled, lower area always enabled on request
    assert_foreign_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= FOREIGN_BASE) |-> !ram_en);
    assert_ram_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && cpu_addr < FOREIGN_BASE) |-> ram_en);
endmodule

// File: tb/aux_bank_xlate_test.sv
module aux_bank_xlate_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        mem_req = 1'b0;
    logic        mem_wr = 1'b0;
    logic        f_alt = 1'b0, f_rd = 1'b0, f_wr = 1'b0;
    logic        f_store = 1'b0, f_page2 = 1'b0, f_hires = 1'b0;
    logic [7:0]  wdata = '0;
    logic [16:0] phys_addr;
    logic        ram_en;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_bank_xlate uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_req(mem_req),
        .mem_wr(mem_wr), .sw_alt_zp(f_alt), .sw_rd_aux(f_rd), .sw_wr_aux(f_wr),
        .sw_store(f_store), .sw_page2(f_page2), .sw_hires(f_hires),
        .phys_addr(phys_addr), .ram_en(ram_en)
    );

    // RAM model
    always @(posedge clk)
        if (rst_n && mem_req && mem_wr && ram_en) mem[int'(phys_addr)] = wdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected half, derived from the requirements
    function automatic logic exp_aux(input logic [15:0] a, input logic wr);
        if (a < 16'h0200) return f_alt;
        if (a >= 16'h0400 && a < 16'h0800 && f_store) return f_page2;
        if (a >= 16'h2000 && a < 16'h4000 && f_store && f_hires) return f_page2;
        return wr ? f_wr : f_rd;
    endfunction

    // Apply flags (bench copies already set), let one edge register them
    task automatic commit;
        @(negedge clk); mem_req = 1'b0;
        @(posedge clk);
    endtask

    task automatic acc(input logic [15:0] a, input logic wr, input logic [7:0] d,
                       output logic [7:0] q, input string tag);
        @(negedge clk);
        cpu_addr = a; mem_wr = wr; wdata = d; mem_req = 1'b1;
        #1;
        chk({tag, " en"}, ram_en, a < 16'hC000);
        if (a < 16'hC000) chk({tag, " phys"}, phys_addr, {exp_aux(a, wr), a});
        q = mem.exists(int'(phys_addr)) ? mem[int'(phys_addr)] : 8'h00;
        @(posedge clk);
    endtask

    task automatic set_flags(input logic alt, rd, wr, st, p2, hr);
        @(negedge clk);
        f_alt = alt; f_rd = rd; f_wr = wr; f_store = st; f_page2 = p2; f_hires = hr;
        commit();
    endtask

    task automatic t_reset_R8;
        logic [7:0] q;
        @(negedge clk);
        rst_n = 1'b0;
        f_alt = 1; f_rd = 1; f_wr = 1; f_store = 1; f_page2 = 1; f_hires = 1;
        mem_req = 1'b1; mem_wr = 1'b0; cpu_addr = 16'h0010;
        @(posedge clk); @(negedge clk);
        chk("R8 zp read main in reset", phys_addr, 17'h00010);
        cpu_addr = 16'h2100; mem_wr = 1'b1; #1;
        chk("R8 hires write main in reset", phys_addr, 17'h02100);
        rst_n = 1'b1; cpu_addr = 16'h4000; mem_wr = 1'b0; #1;
        chk("R8 gen read main after reset", phys_addr, 17'h04000);
        @(posedge clk); #1;
        chk("R8 flags take effect after first edge", phys_addr, 17'h14000);
        set_flags(0, 0, 0, 0, 0, 0);
        acc(16'h0400, 0, 0, q, "R8 text main");
    endtask

    task automatic t_zp_R2;
        logic [7:0] q;
        set_flags(1, 0, 0, 0, 0, 0);
        acc(16'h0000, 1, 8'h11, q, "R2 zp write aux");
        acc(16'h01FF, 0, 0, q, "R2 zp top read aux");
        set_flags(0, 1, 1, 0, 0, 0);
        acc(16'h0000, 1, 8'h22, q, "R2 zp write main");
        acc(16'h0000, 0, 0, q, "R2 zp read main");
        chk("R2 main data", q, 8'h22);
        set_flags(1, 0, 0, 0, 0, 0);
        acc(16'h0000, 0, 0, q, "R2 zp read aux");
        chk("R2 aux data", q, 8'h11);
    endtask

    // Write both halves under opposite settings, read back each
    task automatic sep(input logic [15:0] a, input string tag);
        logic [7:0] q;
        set_flags(0, 0, 1, 0, 0, 0);
        acc(a, 1, 8'hA5, q, {tag, " wr aux"});
        set_flags(0, 1, 0, 0, 0, 0);
        acc(a, 1, 8'h5A, q, {tag, " wr main"});
        acc(a, 0, 0, q, {tag, " rd aux"});
        chk({tag, " aux data"}, q, 8'hA5);
        set_flags(0, 0, 1, 0, 0, 0);
        acc(a, 0, 0, q, {tag, " rd main"});
        chk({tag, " main data"}, q, 8'h5A);
    endtask

    task automatic t_select_R3;
        logic [7:0] q;
        for (int s = 0; s < 4; s++) begin
            set_flags(0, s[0], s[1], 0, 0, 0);
            acc(16'h0300, 0, 0, q, "R3 0200 read");
            acc(16'h0300, 1, 8'h00, q, "R3 0200 write");
            acc(16'h1FFF, 0, 0, q, "R3 0800 read");
            acc(16'h0800, 1, 8'h00, q, "R3 0800 write");
            acc(16'hBFFF, 0, 0, q, "R3 4000 read");
            acc(16'h4000, 1, 8'h00, q, "R3 4000 write");
        end
        sep(16'h0280, "R3 sep 0200");
        sep(16'h1000, "R3 sep 0800");
        sep(16'h8000, "R3 sep 4000");
    endtask

    task automatic t_hires_R4_R5;
        logic [7:0] q;
        set_flags(0, 0, 0, 1, 1, 1);
        acc(16'h2000, 1, 8'h77, q, "R4 page2 write aux");
        acc(16'h3FFF, 0, 0, q, "R4 page2 read aux");
        set_flags(0, 1, 1, 1, 0, 1);
        acc(16'h2000, 1, 8'h88, q, "R4 page1 write main");
        acc(16'h2000, 0, 0, q, "R4 page1 read main");
        chk("R4 main data", q, 8'h88);
        set_flags(0, 0, 0, 1, 1, 1);
        acc(16'h2000, 0, 0, q, "R4 page2 read aux");
        chk("R4 aux data", q, 8'h77);
        for (int s = 0; s < 4; s++) begin
            set_flags(0, s[0], s[1], 1, 1, 0);
            acc(16'h2400, 0, 0, q, "R5 store no hires read");
            acc(16'h2400, 1, 8'h00, q, "R5 store no hires write");
            set_flags(0, s[0], s[1], 0, 1, 1);
            acc(16'h3000, 0, 0, q, "R5 hires no store read");
            acc(16'h3000, 1, 8'h00, q, "R5 hires no store write");
        end
        sep(16'h2800, "R5 sep 2000");
    endtask

    task automatic t_text_R6;
        logic [7:0] q;
        set_flags(0, 0, 0, 1, 1, 0);
        acc(16'h0400, 1, 8'h33, q, "R6 store page2 write aux");
        acc(16'h07FF, 0, 0, q, "R6 store page2 read aux");
        set_flags(0, 1, 1, 1, 0, 0);
        acc(16'h0400, 0, 0, q, "R6 store page1 read main");
        acc(16'h0400, 1, 8'h00, q, "R6 store page1 write main");
        for (int s = 0; s < 4; s++) begin
            set_flags(0, s[0], s[1], 0, 1, 1);
            acc(16'h0500, 0, 0, q, "R6 no store read");
            acc(16'h0500, 1, 8'h00, q, "R6 no store write");
        end
        sep(16'h0600, "R6 sep 0400");
    endtask

    task automatic t_foreign_R7;
        logic [7:0] q;
        set_flags(1, 1, 1, 1, 1, 1);
        acc(16'hC000, 0, 0, q, "R7 C000");
        acc(16'hD123, 1, 8'hEE, q, "R7 D123 write");
        acc(16'hFFFF, 0, 0, q, "R7 FFFF");
        acc(16'hBFFF, 0, 0, q, "R7 BFFF edge");
        chk("R7 no write stored above C000", mem.exists(32'h1D123) || mem.exists(32'h0D123), 0);
        @(negedge clk); mem_req = 1'b0; cpu_addr = 16'h1000; #1;
        chk("R7 no request no enable", ram_en, 1'b0);
    endtask

    task automatic t_latency_R9;
        set_flags(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        mem_req = 1'b1; mem_wr = 1'b0; cpu_addr = 16'h5000; f_rd = 1'b1; #1;
        chk("R9 before edge old select", phys_addr, 17'h05000);
        @(posedge clk); #1;
        chk("R9 after edge new select", phys_addr, 17'h15000);
        cpu_addr = 16'h0100; #1;
        chk("R1 R9 address path same cycle", phys_addr, 17'h00100);
        @(negedge clk); mem_req = 1'b0;
    endtask

    bit done = 0;
    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset_R8();
        t_zp_R2();
        t_select_R3();
        t_hires_R4_R5();
        t_text_R6();
        t_foreign_R7();
        t_latency_R9();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule